// File: doc/BRIEF.md
# Interval Timer with Green Countdown

This block measures elapsed time for a traffic-light state machine. A prescaler divides the system clock into ticks of one second. A single elapsed-seconds counter runs from those ticks. Four threshold comparators read the counter and raise flags for four intervals:

- the minimum green time,
- the walk-light time,
- the amber time,
- the all-red time.

The state machine decides which flag matters in its current state. It restarts the measurement by pulsing a synchronous restart input on the transition into each new state.

The block also outputs a binary countdown of the whole seconds left before the current green may turn amber. It is meant to feed a display driver. The asynchronous reset only brings the timer to a known state at power-up. Restarting an interval during operation always goes through the synchronous input. The elapsed count never wraps. It stops at the largest of the four thresholds, so every flag that has become true stays true.

Top module: `interval_timer`

## Requirements
- R1: After reset is released with restart low, all of the following hold: `elapsed_o` is 0, `countdown_o` equals GREEN_S, `tick_o` is low, and each `tap_o` bit whose threshold is non-zero is low.
- R2: With restart low, `tick_o` is high for exactly one clock in every TICK_DIV = CLK_HZ/TICK_HZ clocks. The first pulse comes in the TICK_DIV-th clock after the restart edge or reset release.
- R3: `elapsed_o` rises by exactly one in the clock after each `tick_o` pulse, and is otherwise unchanged while restart is low.
- R4: `elapsed_o` stops at the largest of GREEN_S, WALK_S, AMBER_S and ALLRED_S and never exceeds it.
- R5: The `tap_o` bits are assigned as follows: bit 0 is minimum green (GREEN_S), bit 1 is walk (WALK_S), bit 2 is amber (AMBER_S), bit 3 is all-red (ALLRED_S). A bit is high exactly when `elapsed_o` is at least its threshold, and it stays high until a restart.
- R6: `countdown_o` equals GREEN_S minus `elapsed_o`, held at 0 once `elapsed_o` reaches or passes GREEN_S. It only ever falls by one per step.
- R7: A restart takes priority over a tick. In a cycle with restart high, `tick_o` is low. In the next cycle `elapsed_o` is 0 and the prescaler phase has restarted.
- R8: While restart is held high for several clocks, `tick_o` stays low and `elapsed_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 100 Hz |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| restart_i | input | 1 | Synchronous restart of the measured interval |
| tick_o | output | 1 | One-clock pulse per elapsed second |
| elapsed_o | output | CW | Whole seconds since the last restart, saturating |
| tap_o | output | 4 | Interval-reached flags (bit order in R5) |
| countdown_o | output | CW | Seconds left until green may turn amber |

## Verification
Two events can fall in the same clock:

- **Restart and tick.** The bench provokes this by running restarts after every run length from zero up past saturation. Some of these run lengths put the restart exactly on the clock whose prescaler phase would emit a tick. The bench then judges that the tick is suppressed and that the count reads zero on the next clock rather than one.
- **Tick at the saturation limit.** A tick that arrives once the count has reached its limit must not move the count, the flags or the countdown. The sweep covers this because it keeps sampling for several ticks past the largest threshold.

All expected values are computed from the run length by division and minimum.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  // Fixed bit positions of the interval flags on the tap output.
  typedef enum int {
    TAP_GREEN  = 0,
    TAP_WALK   = 1,
    TAP_AMBER  = 2,
    TAP_ALLRED = 3
  } tap_idx_e;

  localparam int N_TAPS = 4;

  // Largest of four interval lengths; sets the saturation point.
  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Difference that stops at zero instead of going negative.
  function automatic int sat_sub(int minuend, int subtrahend);
    return (minuend > subtrahend) ? (minuend - subtrahend) : 0;
  endfunction

  // Bits needed to hold values 0..v (at least one).
  function automatic int width_for(int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV < 2) ? 1 : $clog2(DIV);

  generate
    if (DIV < 2) begin : g_pass
      // Every clock is a tick unless a restart is in progress.
      assign tick = !restart;
    end else begin : g_div
      logic [PW-1:0] phase;
      logic          phase_end;

      assign phase_end = (phase == PW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         phase <= '0;
        else if (restart)   phase <= '0;
        else if (phase_end) phase <= '0;
        else                phase <= phase + 1'b1;
      end

      assign tick = phase_end && !restart;

      p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      p_restart_rephase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
      p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PW'(DIV - 1));
    end
  endgenerate

endmodule

// File: rtl/elapsed_counter.sv
module elapsed_counter #(
  parameter int LIMIT = 10,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  assign at_limit = (count == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (restart)           count <= '0;
    else if (tick && !at_limit) count <= count + 1'b1;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(LIMIT));
  p_hold_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !restart) |=> at_limit);
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (count == $past(count) || count == $past(count) + 1'b1));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(count));
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

endmodule

// File: rtl/tap_bank.sv
module tap_bank
  import interval_timer_pkg::*;
#(
  parameter int                    CW      = 4,
  parameter logic [N_TAPS*32-1:0]  THR_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CW-1:0]     count,
  output logic [N_TAPS-1:0] hit
);
  generate
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
      localparam int THR = int'(THR_VEC[i*32 +: 32]);
      // The count only rises between restarts, so a plain compare is sticky.
      assign hit[i] = (32'(count) >= THR);

      p_tap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[i] && !restart) |=> hit[i]);
    end
  endgenerate

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int CLK_HZ   = 100,
  parameter int TICK_HZ  = 1,
  parameter int GREEN_S  = 10,
  parameter int WALK_S   = 5,
  parameter int AMBER_S  = 3,
  parameter int ALLRED_S = 2,
  localparam int TICK_DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ,
  localparam int LIMIT    = max_of4(GREEN_S, WALK_S, AMBER_S, ALLRED_S),
  localparam int CW       = width_for(LIMIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  output logic              tick_o,
  output logic [CW-1:0]     elapsed_o,
  output logic [N_TAPS-1:0] tap_o,
  output logic [CW-1:0]     countdown_o
);
  localparam logic [N_TAPS*32-1:0] THR_VEC =
    {32'(ALLRED_S), 32'(AMBER_S), 32'(WALK_S), 32'(GREEN_S)};

  // Named internal events for the assertions.
  logic          sec_tick;
  logic [CW-1:0] secs;
  logic          secs_full;

  tick_prescaler #(.DIV(TICK_DIV)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_i),
    .tick    (sec_tick)
  );

  elapsed_counter #(.LIMIT(LIMIT), .CW(CW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart_i),
    .tick     (sec_tick),
    .count    (secs),
    .at_limit (secs_full)
  );

  tap_bank #(.CW(CW), .THR_VEC(THR_VEC)) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_i),
    .count   (secs),
    .hit     (tap_o)
  );

  assign tick_o      = sec_tick;
  assign elapsed_o   = secs;
  assign countdown_o = CW'(sat_sub(GREEN_S, int'(secs)));

  p_countdown_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> (countdown_o == $past(countdown_o) ||
                    countdown_o == $past(countdown_o) - 1'b1));
  p_countdown_amber_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[TAP_GREEN] |-> (countdown_o == '0));
  p_restart_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (countdown_o == CW'(GREEN_S)));
  p_no_tick_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (secs_full && sec_tick) |=> $stable(elapsed_o));

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  localparam int DIV = 4;
  localparam int GR = 5, WK = 3, AM = 2, AR = 1;
  localparam int MAXV = 5;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_i = 1'b0;
  logic tick_o;
  logic [CW-1:0] elapsed_o, countdown_o;
  logic [3:0] tap_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  interval_timer #(.CLK_HZ(DIV), .TICK_HZ(1), .GREEN_S(GR), .WALK_S(WK),
                   .AMBER_S(AM), .ALLRED_S(AR)) i_interval_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .tick_o(tick_o),
    .elapsed_o(elapsed_o), .tap_o(tap_o), .countdown_o(countdown_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected state c clocks after a restart edge (or reset release).
  task automatic chk_run(int c);
    int e, tp;
    e = (c / DIV < MAXV) ? c / DIV : MAXV;
    tp = ((e >= GR) ? 1 : 0) | ((e >= WK) ? 2 : 0) | ((e >= AM) ? 4 : 0) | ((e >= AR) ? 8 : 0);
    chk("R2 tick", int'(tick_o), (c % DIV == DIV - 1) ? 1 : 0);
    chk("R3/R4 elapsed", int'(elapsed_o), e);
    chk("R5 taps", int'(tap_o), tp);
    chk("R6 countdown", int'(countdown_o), (GR > e) ? GR - e : 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 elapsed", int'(elapsed_o), 0);
    chk("R1 countdown", int'(countdown_o), GR);
    chk("R1 tick", int'(tick_o), 0);
    chk("R1 taps", int'(tap_o), 0);
    rst_n = 1'b1;
    // Run from reset release: same timeline as after a restart.
    for (int c = 0; c < (MAXV + 2) * DIV; c++) begin
      chk_run(c);
      @(negedge clk);
    end
    // Restart after every run length, including on tick phases (R7).
    for (int len = 0; len <= (MAXV + 2) * DIV; len++) begin
      restart_i = 1'b1;
      #1;
      chk("R7 tick suppressed", int'(tick_o), 0);
      @(negedge clk);
      restart_i = 1'b0;
      chk("R7 cleared", int'(elapsed_o), 0);
      for (int c = 0; c < len; c++) begin
        chk_run(c);
        @(negedge clk);
      end
    end
    // R8: held restart
    restart_i = 1'b1;
    for (int k = 0; k < 3 * DIV; k++) begin
      @(negedge clk);
      chk("R8 tick", int'(tick_o), 0);
      chk("R8 elapsed", int'(elapsed_o), 0);
    end
    @(negedge clk);
    restart_i = 1'b0;
    for (int c = 0; c < 2 * DIV; c++) begin
      chk_run(c);
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule